// File: doc/BRIEF.md
# Parallel Bit Gather Unit

This unit compresses scattered bits of a 64-bit word into a dense field. It takes a source word and a selection mask. Every source bit that sits under a set mask bit is copied into the result. The copied bits keep their relative order and pack into the low end of the result, and all result bits above the packed field are cleared. A small combinational decoder beside the execution engine recognises the matching 32-bit instruction word, splits out the three register index fields, and raises an illegal-instruction flag when the word matches but the core is not in 64-bit mode or lacks the required feature level.

The engine takes one cycle per set mask bit. In each cycle it locates the lowest remaining mask bit, copies the source bit at that position into the next output slot, then clears that mask bit. A mask of all ones, which leaves the source unchanged, and a mask of all zeros, which gives zero, both finish in a single cycle. The caller pulses `start` with both operands present, waits while `busy` is high, and takes `result` in the cycle where `done` pulses.

Top module: `bitgather_unit`

## Requirements
- R1: `decValid` is high exactly when `insnWord[31:26]` = 011111, `insnWord[10:1]` = 0010111100, `mode64` = 1 and `isaOk` = 1. `insnWord[0]` has no effect on any decoder output.
- R2: `rsIdx` = `insnWord[25:21]` (source register), `raIdx` = `insnWord[20:16]` (destination register) and `rbIdx` = `insnWord[15:11]` (mask register).
- R3: `illegal` is high when the opcode fields match but `mode64` or `isaOk` is 0. A word whose primary or extended opcode differs raises neither `illegal` nor `decValid`.
- R4: Let m0 < m1 < ... be the positions of the set bits of the mask. Then result bit j equals source bit mj.
- R5: Result bits at and above the popcount of the mask are 0, so an all-zero mask gives a result of 0.
- R6: An all-ones mask gives `result` equal to the source, with `done` high in the cycle after `start` is sampled.
- R7: For a mask with k set bits, where 0 < k < 64, `done` is high k cycles after the edge that samples `start`. An all-zero mask completes after 1 cycle.
- R8: `busy` is high from the edge that accepts a multi-cycle operation until completion. `done` is high for exactly one cycle and never together with `busy`.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes with its original operands and timing.
- R10: Reset clears `busy`, `done` and `result` to 0, including when reset arrives in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insnWord | input | 32 | Instruction word to decode |
| mode64 | input | 1 | Core runs in 64-bit mode |
| isaOk | input | 1 | Required feature level is enabled |
| decValid | output | 1 | Word is this operation and may execute |
| illegal | output | 1 | Word is this operation but is not permitted |
| rsIdx | output | 5 | Source register index |
| raIdx | output | 5 | Destination register index |
| rbIdx | output | 5 | Mask register index |
| start | input | 1 | One-cycle request; captures srcData and maskData |
| srcData | input | 64 | Source word |
| maskData | input | 64 | Selection mask |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Gathered result, valid when done is high |

## Verification
The hardest situation to reach from the ports is a second request that arrives while an operation is still iterating. If such a request were accepted, it would corrupt both the result and the latency. To reach it, the stimulus pulses `start` with fresh random operands one cycle into a long operation, then checks the original result and the original cycle count. Reset in the middle of an operation is driven the same way. The bench also sweeps all 64 single-bit masks, which exercise every trailing-zero position, and uses both alternating patterns to get 32-step runs. Each of these runs is compared cycle by cycle against a behavioural gather loop and a popcount latency model.

// File: rtl/bgu_pkg.sv
package bgu_pkg;
  typedef struct packed {
    logic loadPass;
    logic loadZero;
    logic loadIter;
    logic step;
  } bguStrobe_t;
endpackage

// File: rtl/bgu_decode.sv
module bgu_decode #(
  parameter int IW = 32,
  parameter int RW = 5,
  parameter logic [IW-1:0] MATCH_MASK = {6'h3F, 15'h0, 10'h3FF, 1'b0},
  parameter logic [IW-1:0] MATCH_VAL  = {6'b011111, 15'h0, 10'b0010111100, 1'b0}
) (
  input  logic [IW-1:0] insnWord,
  input  logic          mode64,
  input  logic          isaOk,
  output logic          decValid,
  output logic          illegal,
  output logic [RW-1:0] rsIdx,
  output logic [RW-1:0] raIdx,
  output logic [RW-1:0] rbIdx
);
  logic insnHit;
  logic permitted;

  always_comb begin
    insnHit   = (insnWord & MATCH_MASK) == MATCH_VAL;
    permitted = mode64 && isaOk;
    decValid  = insnHit && permitted;
    illegal   = insnHit && !permitted;
    rsIdx     = insnWord[IW-7 -: RW];
    raIdx     = insnWord[IW-7-RW -: RW];
    rbIdx     = insnWord[IW-7-2*RW -: RW];
  end

  always_comb begin
    if (!$isunknown({decValid, illegal})) begin
      p_flags_exclusive_r3: assert (!(decValid && illegal));
    end
  end
endmodule

// File: rtl/bgu_datapath.sv
module bgu_datapath
  import bgu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  bguStrobe_t   strb,
  input  logic [W-1:0] srcIn,
  input  logic [W-1:0] maskIn,
  output logic         maskOnes,
  output logic         maskZero,
  output logic         lastBit,
  output logic [W-1:0] result
);
  localparam int PW = $clog2(W);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]  srcReg, maskReg, resReg;
  logic [PW-1:0] outPos, lowIdx;

  function automatic logic [PW-1:0] lowestSet(input logic [W-1:0] v);
    logic [PW-1:0] idx;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) idx = PW'(i);
    end
    return idx;
  endfunction

  always_comb begin
    maskOnes = &maskIn;
    maskZero = ~|maskIn;
    lowIdx   = lowestSet(maskReg);
    lastBit  = (maskReg & (maskReg - ONE)) == '0;
    result   = resReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg  <= '0;
      maskReg <= '0;
      resReg  <= '0;
      outPos  <= '0;
    end else if (strb.loadPass) begin
      resReg <= srcIn;
    end else if (strb.loadZero) begin
      resReg <= '0;
    end else if (strb.loadIter) begin
      srcReg  <= srcIn;
      maskReg <= maskIn;
      resReg  <= '0;
      outPos  <= '0;
    end else if (strb.step) begin
      resReg[outPos] <= srcReg[lowIdx];
      maskReg        <= maskReg & (maskReg - ONE);
      outPos         <= outPos + PW'(1);
    end
  end

  p_step_has_bit_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> (maskReg != '0));

  p_upper_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> ((resReg >> outPos) == '0));
endmodule

// File: rtl/bgu_ctrl.sv
module bgu_ctrl
  import bgu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       maskOnes,
  input  logic       maskZero,
  input  logic       lastBit,
  output bguStrobe_t strb,
  output logic       busy,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;
  ctrlState_t state;
  logic accept;

  always_comb begin
    accept = start && (state == ST_IDLE);
    strb   = '0;
    if (accept) begin
      if (maskOnes)      strb.loadPass = 1'b1;
      else if (maskZero) strb.loadZero = 1'b1;
      else               strb.loadIter = 1'b1;
    end
    strb.step = (state == ST_RUN);
    busy      = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          if (maskOnes || maskZero) done  <= 1'b1;
          else                      state <= ST_RUN;
        end
        ST_RUN: if (lastBit) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);

  p_busy_not_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);

  p_fast_finish_r6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (maskOnes || maskZero)) |=> (done && !busy));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastBit) |=> (busy && !done));
endmodule

// File: rtl/bitgather_unit.sv
module bitgather_unit
  import bgu_pkg::*;
#(
  parameter int W  = 64,
  parameter int IW = 32,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [IW-1:0] insnWord,
  input  logic          mode64,
  input  logic          isaOk,
  output logic          decValid,
  output logic          illegal,
  output logic [RW-1:0] rsIdx,
  output logic [RW-1:0] raIdx,
  output logic [RW-1:0] rbIdx,
  input  logic          start,
  input  logic [W-1:0]  srcData,
  input  logic [W-1:0]  maskData,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result
);
  bguStrobe_t strb;
  logic maskOnes, maskZero, lastBit;

  bgu_decode #(.IW(IW), .RW(RW)) uDec (
    .insnWord(insnWord), .mode64(mode64), .isaOk(isaOk),
    .decValid(decValid), .illegal(illegal),
    .rsIdx(rsIdx), .raIdx(raIdx), .rbIdx(rbIdx)
  );

  bgu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .maskOnes(maskOnes), .maskZero(maskZero), .lastBit(lastBit),
    .strb(strb), .busy(busy), .done(done)
  );

  bgu_datapath #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srcIn(srcData), .maskIn(maskData),
    .maskOnes(maskOnes), .maskZero(maskZero), .lastBit(lastBit),
    .result(result)
  );
endmodule

// File: tb/bitgather_unit_test.sv
module bitgather_unit_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, mode64, isaOk, start;
  logic [31:0] insnWord;
  logic [63:0] srcData, maskData, result;
  logic        decValid, illegal, busy, done;
  logic [4:0]  rsIdx, raIdx, rbIdx;
  int vectors = 0;
  int errs = 0;

  bitgather_unit uut (
    .clk(clk), .rstN(rstN), .insnWord(insnWord), .mode64(mode64), .isaOk(isaOk),
    .decValid(decValid), .illegal(illegal), .rsIdx(rsIdx), .raIdx(raIdx), .rbIdx(rbIdx),
    .start(start), .srcData(srcData), .maskData(maskData),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] gather(input logic [63:0] s, input logic [63:0] m);
    logic [63:0] r;
    int o;
    r = '0;
    o = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i]) begin
        r[o] = s[i];
        o++;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] mkInsn(input logic [5:0] po, input logic [4:0] a,
      input logic [4:0] b, input logic [4:0] c, input logic [9:0] xo, input logic lsb);
    return {po, a, b, c, xo, lsb};
  endfunction

  // poke: raise start with other operands one cycle into the run (R9)
  task automatic runOp(input logic [63:0] s, input logic [63:0] m,
                       input string tag, input bit poke);
    logic [63:0] exp;
    int lat;
    exp = gather(s, m);
    lat = (m == '1 || m == '0) ? 0 : $countones(m);
    @(negedge clk);
    srcData = s; maskData = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < lat; j++) begin
      check(busy && !done, "R8", "busy during run", {62'b0, busy, done}, 64'h2);
      if (poke && j == 0) begin
        srcData = {$urandom, $urandom}; maskData = 64'h1; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(done && !busy, (m == '1) ? "R6" : "R7", "done at expected cycle",
          {62'b0, busy, done}, 64'h1);
    check(result == exp, poke ? "R9" : tag, "result", result, exp);
    @(negedge clk);
    check(!done, "R8", "done single pulse", {63'b0, done}, 64'h0);
  endtask

  initial begin
    #(200000 * 8);
    errs++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; srcData = '0; maskData = '0;
    mode64 = 1'b1; isaOk = 1'b1; insnWord = '0;
    repeat (2) @(negedge clk);
    check(!busy && !done && result == 0, "R10", "reset state", result, 64'h0);
    rstN = 1'b1;

    // decoder
    insnWord = mkInsn(6'b011111, 5'd3, 5'd17, 5'd30, 10'b0010111100, 1'b0);
    #1;
    check(decValid && !illegal, "R1", "decode match", {62'b0, decValid, illegal}, 64'h2);
    check(rsIdx == 3 && raIdx == 17 && rbIdx == 30, "R2", "fields",
          {49'b0, rsIdx, raIdx, rbIdx}, {49'b0, 5'd3, 5'd17, 5'd30});
    insnWord[0] = 1'b1;
    #1;
    check(decValid && !illegal, "R1", "low bit ignored", {62'b0, decValid, illegal}, 64'h2);
    mode64 = 1'b0;
    #1;
    check(!decValid && illegal, "R3", "no 64-bit mode", {62'b0, decValid, illegal}, 64'h1);
    mode64 = 1'b1; isaOk = 1'b0;
    #1;
    check(!decValid && illegal, "R3", "no feature level", {62'b0, decValid, illegal}, 64'h1);
    isaOk = 1'b1;
    insnWord = mkInsn(6'b011111, 5'd1, 5'd2, 5'd4, 10'b0010011100, 1'b0);
    #1;
    check(!decValid && !illegal, "R3", "wrong extended opcode", {62'b0, decValid, illegal}, 64'h0);
    insnWord = mkInsn(6'b011110, 5'd1, 5'd2, 5'd4, 10'b0010111100, 1'b0);
    #1;
    check(!decValid && !illegal, "R3", "wrong primary opcode", {62'b0, decValid, illegal}, 64'h0);

    // fast paths
    runOp(64'hDEAD_BEEF_0123_4567, '1, "R6", 1'b0);
    runOp(64'hFFFF_FFFF_FFFF_FFFF, '0, "R5", 1'b0);
    // single-bit masks, every position
    for (int p = 0; p < 64; p++) runOp({$urandom, $urandom}, 64'h1 << p, "R4", 1'b0);
    // alternating masks
    runOp({$urandom, $urandom}, 64'h5555_5555_5555_5555, "R4", 1'b0);
    runOp({$urandom, $urandom}, 64'hAAAA_AAAA_AAAA_AAAA, "R5", 1'b0);
    // near-full mask, 63 steps
    runOp({$urandom, $urandom}, 64'h7FFF_FFFF_FFFF_FFFF, "R7", 1'b0);
    // random dense and sparse masks
    for (int n = 0; n < 40; n++) runOp({$urandom, $urandom}, {$urandom, $urandom}, "R4", 1'b0);
    for (int n = 0; n < 20; n++)
      runOp({$urandom, $urandom}, {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} | 64'h1,
            "R5", 1'b0);
    // start while busy is ignored
    runOp(64'h0123_4567_89AB_CDEF, 64'h0F0F_0000_F0F0_00FF, "R9", 1'b1);
    runOp({$urandom, $urandom}, 64'h8000_0000_0000_0003, "R9", 1'b1);

    // reset mid-operation
    @(negedge clk);
    srcData = '1; maskData = 64'h00FF_00FF_00FF_00FF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!busy && !done && result == 0, "R10", "reset mid-run", result, 64'h0);
    rstN = 1'b1;
    runOp(64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0FF0, "R4", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule